// File: doc/BRIEF.md
# Four-Channel DMA Register Controller

This block is the programming front end and the address/count engine of a four-channel DMA controller. A host reaches it through an 8-bit port bus with a 4-bit port offset. Each channel keeps a 16-bit base address and a 16-bit base count, plus current copies that advance as transfers happen. The 16-bit values move over the 8-bit bus one byte at a time. A single byte-pointer flag, shared by all channels, decides whether an access hits the low byte or the high byte, and every such access flips it.

Ports also exist for the command byte, the per-channel mode, a single-channel mask, a clear-all-masks strobe, a write-all-masks port, a master clear and a status read. An external arbiter picks a channel and pulses the transfer strobe. On each strobe the block steps that channel's current address up or down, steps its count down, and handles terminal count. At terminal count the channel either reloads its base values or masks itself.

Read data is registered. It shows up on `rd_data` in the cycle after `rd_en` is sampled.

Top module: `dmac_regs`

## Requirements
- R1: After reset, `chan_mask` is 4'hF, `ack_hi`, `req_hi`, `rot_prio` and `chan_mode` are zero, the byte pointer selects the low byte, and all terminal-count flags are clear.
- R2: Offsets 0, 2, 4 and 6 access the address of channels 0 to 3, and offsets 1, 3, 5 and 7 access their count. A write loads the base and current copies together. A read returns the current copy. The low byte comes first, then the high byte, and every access at offsets 0 to 7 flips the shared byte pointer.
- R3: A write to offset 0xC returns the byte pointer to the low byte.
- R4: A write to offset 0xA sets or clears the mask of one channel: data bit 2 is the new mask value and bits 1:0 pick the channel.
- R5: A write to offset 0xE clears all four masks. A write to offset 0xF copies data bits 3:0 into the masks of channels 3 to 0.
- R6: A write to offset 0xB stores data bits 7:2 as the mode of the channel in bits 1:0. Bits 7:6 are the transfer kind, bit 5 selects address decrement, bit 4 selects autoinitialise and bits 3:2 are the operation. `chan_mode` shows channel i in bits 6i+5 to 6i. A write whose bits 3:2 are 11 (reserved) leaves the mode unchanged.
- R7: A write to offset 8 sets the command: bit 7 drives `ack_hi`, bit 6 drives `req_hi` and bit 4 drives `rot_prio`. A status read at offset 8 returns the active request of channels 3 to 0 in bits 7:4, where a `req_in` bit counts as active when it equals `req_hi`.
- R8: A transfer strobe on an unmasked channel whose count is not zero decrements the count by one. It moves the address by +1, or by -1 when that channel's decrement bit is set.
- R9: A strobe on an unmasked channel with count 0 is terminal count. It sets that channel's flag in status bits 3:0. Without autoinitialise, the count wraps to 0xFFFF, the address steps as usual and the channel's mask is set.
- R10: At terminal count with autoinitialise set, the current address and count reload from the base values and the mask stays clear.
- R11: A status read returns the terminal-count flags and then clears them.
- R12: A transfer strobe on a masked channel changes no address, count, flag or mask.
- R13: A write to offset 0xD sets all masks, clears the command and all terminal-count flags, and returns the byte pointer to the low byte.
- R14: Reads at offsets 9 to 0xF return zero. A write to offset 9 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe |
| port_off | input | 4 | Port offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| req_in | input | 4 | Raw request lines of channels 3..0 |
| xfer_stb | input | 1 | One transfer done on channel xfer_ch |
| xfer_ch | input | 2 | Channel of the transfer strobe |
| chan_mask | output | 4 | Mask bits of channels 3..0 |
| chan_mode | output | 24 | Stored mode of each channel, 6 bits each |
| ack_hi | output | 1 | Acknowledge polarity, 1 = active high |
| req_hi | output | 1 | Request polarity, 1 = active high |
| rot_prio | output | 1 | Rotating priority selected |

## Verification
The assertions assume three things about the inputs:
- A port access and a transfer strobe never arrive in the same cycle.
- `rd_en` and `wr_en` are never high together.
- The offset is stable while a strobe is high.

The bench drives one operation per cycle pair from sequential tasks, so these conditions always hold. Its random phase mixes register loads, mode writes (including reserved operations), mask writes, strobes on every channel and checked reads. Masked strobes, terminal-count wrap and autoinitialise reloads all come up naturally in that mix.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int NCH = 4;
  localparam int CHW = 2;

  typedef struct packed {
    logic [1:0] kind;
    logic       dec;
    logic       auto_ld;
    logic [1:0] op;
  } mode_t;

  localparam int MW = $bits(mode_t);

  localparam logic [3:0] OFS_CMD  = 4'h8;
  localparam logic [3:0] OFS_MSK1 = 4'hA;
  localparam logic [3:0] OFS_MODE = 4'hB;
  localparam logic [3:0] OFS_FLIP = 4'hC;
  localparam logic [3:0] OFS_MCLR = 4'hD;
  localparam logic [3:0] OFS_MZRO = 4'hE;
  localparam logic [3:0] OFS_MALL = 4'hF;
endpackage

// File: rtl/dmac_decode.sv
`timescale 1ns/1ps
module dmac_decode
  import dmac_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] port_off,
  output logic [2*NCH-1:0] reg_we,
  output logic       reg_acc,
  output logic       cmd_we,
  output logic       mask1_we,
  output logic       mode_we,
  output logic       flip_clr,
  output logic       mclr,
  output logic       mzro_we,
  output logic       mall_we,
  output logic       stat_rd
);
  logic in_file;
  assign in_file = (port_off[3] == 1'b0);

  for (genvar i = 0; i < 2*NCH; i++) begin : g_we
    assign reg_we[i] = wr_en && in_file && (port_off[2:0] == 3'(i));
  end

  assign reg_acc  = (wr_en || rd_en) && in_file;
  assign cmd_we   = wr_en && port_off == OFS_CMD;
  assign mask1_we = wr_en && port_off == OFS_MSK1;
  assign mode_we  = wr_en && port_off == OFS_MODE;
  assign flip_clr = wr_en && port_off == OFS_FLIP;
  assign mclr     = wr_en && port_off == OFS_MCLR;
  assign mzro_we  = wr_en && port_off == OFS_MZRO;
  assign mall_we  = wr_en && port_off == OFS_MALL;
  assign stat_rd  = rd_en && port_off == OFS_CMD;
endmodule

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hi_sel,
  input  logic          addr_we,
  input  logic          cnt_we,
  input  logic [DW-1:0] wdata,
  input  logic          mode_we,
  input  mode_t         mode_in,
  input  logic          xfer,
  output logic [2*DW-1:0] cur_addr,
  output logic [2*DW-1:0] cur_cnt,
  output mode_t         mode_q,
  output logic          tc_hit
);
  localparam int AW = 2*DW;

  logic [AW-1:0] base_addr, base_cnt;
  logic          reload;

  assign tc_hit = xfer && (cur_cnt == '0);
  assign reload = tc_hit && mode_q.auto_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode_q    <= '0;
    end else begin
      if (reload) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else if (xfer) begin
        cur_addr <= mode_q.dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
        cur_cnt  <= cur_cnt - 1'b1;
      end
      if (addr_we) begin
        if (hi_sel) begin
          base_addr[AW-1:DW] <= wdata;
          cur_addr[AW-1:DW]  <= wdata;
        end else begin
          base_addr[DW-1:0] <= wdata;
          cur_addr[DW-1:0]  <= wdata;
        end
      end
      if (cnt_we) begin
        if (hi_sel) begin
          base_cnt[AW-1:DW] <= wdata;
          cur_cnt[AW-1:DW]  <= wdata;
        end else begin
          base_cnt[DW-1:0] <= wdata;
          cur_cnt[DW-1:0]  <= wdata;
        end
      end
      if (mode_we) mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        port_off,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH-1:0]    req_in,
  input  logic              xfer_stb,
  input  logic [CHW-1:0]    xfer_ch,
  output logic [NCH-1:0]    chan_mask,
  output logic [NCH*MW-1:0] chan_mode,
  output logic              ack_hi,
  output logic              req_hi,
  output logic              rot_prio
);
  localparam int AW = 2*DW;

  logic [2*NCH-1:0] reg_we;
  logic reg_acc, cmd_we, mask1_we, mode_we, flip_clr, mclr, mzro_we, mall_we, stat_rd;

  dmac_decode u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .port_off(port_off),
    .reg_we(reg_we), .reg_acc(reg_acc), .cmd_we(cmd_we), .mask1_we(mask1_we),
    .mode_we(mode_we), .flip_clr(flip_clr), .mclr(mclr), .mzro_we(mzro_we),
    .mall_we(mall_we), .stat_rd(stat_rd)
  );

  logic           flip_q;
  logic [NCH-1:0] mask_q, tc_q, tc_hit, auto_v;
  logic [2:0]     cmd_q;
  logic [DW-1:0]  rd_q;
  logic [AW-1:0]  cur_a [NCH];
  logic [AW-1:0]  cur_c [NCH];
  logic [NCH*AW-1:0] cnt_flat, addr_flat;
  mode_t          mode_v [NCH];
  mode_t          mode_in;

  assign mode_in = mode_t'(wr_data[7:2]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic xfer_ok, mwe;
    assign xfer_ok = xfer_stb && (xfer_ch == CHW'(i)) && !mask_q[i];
    assign mwe     = mode_we && (wr_data[1:0] == CHW'(i)) && (wr_data[3:2] != 2'b11);
    dmac_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst), .hi_sel(flip_q),
      .addr_we(reg_we[2*i]), .cnt_we(reg_we[2*i+1]), .wdata(wr_data),
      .mode_we(mwe), .mode_in(mode_in), .xfer(xfer_ok),
      .cur_addr(cur_a[i]), .cur_cnt(cur_c[i]), .mode_q(mode_v[i]), .tc_hit(tc_hit[i])
    );
    assign auto_v[i] = mode_v[i].auto_ld;
    assign chan_mode[i*MW +: MW] = mode_v[i];
    assign cnt_flat[i*AW +: AW]  = cur_c[i];
    assign addr_flat[i*AW +: AW] = cur_a[i];
  end

  logic [NCH-1:0] req_act;
  assign req_act = cmd_q[1] ? req_in : ~req_in;

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      flip_q <= 1'b0;
      mask_q <= '1;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else begin
      if (flip_clr)     flip_q <= 1'b0;
      else if (reg_acc) flip_q <= ~flip_q;
      mask_q <= mask_q | (tc_hit & ~auto_v);
      if (mask1_we) mask_q[wr_data[1:0]] <= wr_data[2];
      if (mzro_we)  mask_q <= '0;
      if (mall_we)  mask_q <= wr_data[NCH-1:0];
      tc_q <= (stat_rd ? '0 : tc_q) | tc_hit;
      if (cmd_we) cmd_q <= {wr_data[7], wr_data[6], wr_data[4]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      if (!port_off[3]) begin
        logic [AW-1:0] word;
        word = port_off[0] ? cur_c[port_off[2:1]] : cur_a[port_off[2:1]];
        rd_q <= flip_q ? word[AW-1:DW] : word[DW-1:0];
      end else if (port_off == OFS_CMD) begin
        rd_q <= {req_act, tc_q};
      end else begin
        rd_q <= '0;
      end
    end
  end

  assign rd_data   = rd_q;
  assign chan_mask = mask_q;
  assign ack_hi    = cmd_q[2];
  assign req_hi    = cmd_q[1];
  assign rot_prio  = cmd_q[0];
endmodule

// File: rtl/dmac_regs_chk.sv
`timescale 1ns/1ps
module dmac_regs_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [3:0]    port_off,
  input logic          xfer_stb,
  input logic [1:0]    xfer_ch,
  input logic [3:0]    chan_mask,
  input logic [23:0]   chan_mode,
  input logic [3:0]    tc_q,
  input logic [4*AW-1:0] cnt_flat,
  input logic [4*AW-1:0] addr_flat
);
  a_r13_mclr: assert property (@(posedge clk) disable iff (rst)
    wr_en && port_off == 4'hD |=> chan_mask == 4'hF && tc_q == 4'h0);

  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    wr_en && port_off == 4'hE |=> chan_mask == 4'h0);

  a_r11_status_clears: assert property (@(posedge clk) disable iff (rst)
    rd_en && port_off == 4'h8 && !xfer_stb |=> tc_q == 4'h0);

  a_r12_masked_hold: assert property (@(posedge clk) disable iff (rst)
    xfer_stb && chan_mask[xfer_ch] && !wr_en |=> $stable(cnt_flat) && $stable(addr_flat));

  a_r9_tc_masks: assert property (@(posedge clk) disable iff (rst)
    xfer_stb && !wr_en && !chan_mask[xfer_ch] && cnt_flat[xfer_ch*AW +: AW] == '0
      && !chan_mode[xfer_ch*6+2]
    |=> chan_mask[$past(xfer_ch)] && tc_q[$past(xfer_ch)]);

  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    xfer_stb && !wr_en && !chan_mask[xfer_ch] && cnt_flat[xfer_ch*AW +: AW] != '0
    |=> cnt_flat[$past(xfer_ch)*AW +: AW] == ($past(cnt_flat[xfer_ch*AW +: AW]) - 1'b1));
endmodule

bind dmac_regs dmac_regs_chk #(.AW(2*DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_off(port_off),
  .xfer_stb(xfer_stb), .xfer_ch(xfer_ch), .chan_mask(chan_mask), .chan_mode(chan_mode),
  .tc_q(tc_q), .cnt_flat(cnt_flat), .addr_flat(addr_flat)
);

// File: tb/sim_dmac_regs.sv
`timescale 1ns/1ps
module sim_dmac_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, xfer_stb = 1'b0;
  logic [3:0] port_off = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] req_in = 4'hF;
  logic [1:0] xfer_ch = '0;
  logic [3:0] chan_mask;
  logic [23:0] chan_mode;
  logic ack_hi, req_hi, rot_prio;

  always #2.5 clk = ~clk;

  dmac_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_off(port_off),
    .wr_data(wr_data), .rd_data(rd_data), .req_in(req_in), .xfer_stb(xfer_stb),
    .xfer_ch(xfer_ch), .chan_mask(chan_mask), .chan_mode(chan_mode),
    .ack_hi(ack_hi), .req_hi(req_hi), .rot_prio(rot_prio)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] m_ba [4], m_bc [4], m_ca [4], m_cc [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask = 4'hF, m_tc = 4'h0;
  logic [2:0]  m_cmd = 3'b0;
  logic        m_t = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] set_byte(input logic [15:0] w, input logic hi, input logic [7:0] d);
    return hi ? {d, w[7:0]} : {w[15:8], d};
  endfunction

  task automatic model_wr(input logic [3:0] o, input logic [7:0] d);
    int ch;
    ch = int'(o[2:1]);
    if (!o[3]) begin
      if (!o[0]) begin m_ba[ch] = set_byte(m_ba[ch], m_t, d); m_ca[ch] = set_byte(m_ca[ch], m_t, d); end
      else       begin m_bc[ch] = set_byte(m_bc[ch], m_t, d); m_cc[ch] = set_byte(m_cc[ch], m_t, d); end
      m_t = ~m_t;
    end else begin
      case (o)
        4'h8: m_cmd = {d[7], d[6], d[4]};
        4'hA: m_mask[d[1:0]] = d[2];
        4'hB: if (d[3:2] != 2'b11) m_mode[d[1:0]] = d[7:2];
        4'hC: m_t = 1'b0;
        4'hD: begin m_mask = 4'hF; m_cmd = '0; m_tc = '0; m_t = 1'b0; end
        4'hE: m_mask = 4'h0;
        4'hF: m_mask = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic model_rd(input logic [3:0] o, output logic [7:0] q);
    logic [15:0] w;
    int ch;
    ch = int'(o[2:1]);
    if (!o[3]) begin
      w = o[0] ? m_cc[ch] : m_ca[ch];
      q = m_t ? w[15:8] : w[7:0];
      m_t = ~m_t;
    end else if (o == 4'h8) begin
      q = {(m_cmd[1] ? req_in : ~req_in), m_tc};
      m_tc = 4'h0;
    end else q = 8'h00;
  endtask

  task automatic model_xfer(input int ch);
    if (!m_mask[ch]) begin
      if (m_cc[ch] == 16'h0) begin
        m_tc[ch] = 1'b1;
        if (m_mode[ch][2]) begin m_ca[ch] = m_ba[ch]; m_cc[ch] = m_bc[ch]; return; end
        m_mask[ch] = 1'b1;
      end
      m_ca[ch] = m_mode[ch][3] ? m_ca[ch] - 16'd1 : m_ca[ch] + 16'd1;
      m_cc[ch] = m_cc[ch] - 16'd1;
    end
  endtask

  task automatic do_wr(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; port_off = o; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    model_wr(o, d);
  endtask

  task automatic do_rd(input logic [3:0] o, input string tag);
    logic [7:0] exp;
    model_rd(o, exp);
    @(negedge clk); rd_en = 1'b1; port_off = o;
    @(negedge clk); rd_en = 1'b0;
    chk(32'(rd_data), 32'(exp), tag);
  endtask

  task automatic do_stb(input int ch);
    @(negedge clk); xfer_stb = 1'b1; xfer_ch = 2'(ch);
    @(negedge clk); xfer_stb = 1'b0;
    model_xfer(ch);
  endtask

  task automatic wr16(input logic [3:0] o, input logic [15:0] v);
    do_wr(o, v[7:0]); do_wr(o, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] o, input string tag);
    do_rd(o, tag); do_rd(o, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = '0; m_bc[i] = '0; m_ca[i] = '0; m_cc[i] = '0; m_mode[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(32'(chan_mask), 32'hF, "R1 mask");
    chk(32'({ack_hi, req_hi, rot_prio}), 32'h0, "R1 command");
    chk(32'(chan_mode), 32'h0, "R1 mode");
    do_rd(4'h8, "R1 status");

    // R2 byte loading and readback
    wr16(4'h0, 16'h1234);
    do_rd(4'h0, "R2 addr lo");
    chk(32'(rd_data), 32'h34, "R2 addr lo literal");
    do_rd(4'h0, "R2 addr hi");
    chk(32'(rd_data), 32'h12, "R2 addr hi literal");
    wr16(4'h5, 16'h0003);
    rd16(4'h5, "R2 count ch2");

    // R3 pointer clear
    do_wr(4'h2, 8'h77);
    do_wr(4'hC, 8'h00);
    wr16(4'h2, 16'hCDAB);
    do_rd(4'h2, "R3 lo after clear");
    chk(32'(rd_data), 32'hAB, "R3 lo literal");
    do_rd(4'h2, "R3 hi after clear");

    // R4 single mask
    do_wr(4'hA, 8'h00);
    chk(32'(chan_mask), 32'hE, "R4 clear ch0");
    do_wr(4'hA, 8'h04);
    chk(32'(chan_mask), 32'hF, "R4 set ch0");

    // R6 mode and reserved operation
    do_wr(4'hB, 8'h44);
    chk(32'(chan_mode[5:0]), 32'h11, "R6 mode ch0");
    do_wr(4'hB, 8'h4C);
    chk(32'(chan_mode[5:0]), 32'h11, "R6 reserved ignored");

    // R8 increment
    wr16(4'h1, 16'h0003);
    do_wr(4'hA, 8'h00);
    do_stb(0);
    rd16(4'h0, "R8 addr inc");
    rd16(4'h1, "R8 count dec");

    // R8 decrement and R9 terminal count
    do_wr(4'hB, 8'h65);
    wr16(4'h2, 16'h0001);
    wr16(4'h3, 16'h0001);
    do_wr(4'hA, 8'h01);
    do_stb(1);
    do_stb(1);
    rd16(4'h2, "R9 addr wrap");
    rd16(4'h3, "R9 count wrap");
    chk(32'(chan_mask[1]), 32'h1, "R9 mask set");
    // R11 status clears flags
    do_rd(4'h8, "R11 status first");
    chk(32'(rd_data[3:0]), 32'h2, "R11 tc flag ch1");
    do_rd(4'h8, "R11 status second");

    // R10 autoinitialise
    do_wr(4'hB, 8'h9A);
    wr16(4'h4, 16'h0100);
    wr16(4'h5, 16'h0001);
    do_wr(4'hA, 8'h02);
    do_stb(2); do_stb(2); do_stb(2);
    rd16(4'h4, "R10 addr reload");
    rd16(4'h5, "R10 count reload");
    chk(32'(chan_mask[2]), 32'h0, "R10 mask stays clear");
    do_rd(4'h8, "R10 tc flag");

    // R12 masked strobe
    wr16(4'h6, 16'h4000);
    do_stb(3);
    rd16(4'h6, "R12 addr unchanged");
    do_rd(4'h8, "R12 no flag");

    // R7 command and request polarity
    do_wr(4'h8, 8'hD0);
    chk(32'({ack_hi, req_hi, rot_prio}), 32'h7, "R7 command bits");
    req_in = 4'b0101;
    do_rd(4'h8, "R7 request active high");
    do_wr(4'h8, 8'h00);
    do_rd(4'h8, "R7 request active low");

    // R5 write all / clear all
    do_wr(4'hF, 8'h05);
    chk(32'(chan_mask), 32'h5, "R5 write all");
    do_wr(4'hE, 8'h00);
    chk(32'(chan_mask), 32'h0, "R5 clear all");

    // R14 unused offsets
    do_wr(4'h9, 8'hFF);
    chk(32'(chan_mask), 32'h0, "R14 write 9 ignored");
    do_rd(4'h9, "R14 read 9");
    do_rd(4'hE, "R14 read E");

    // R13 master clear
    do_wr(4'h0, 8'h55);
    do_wr(4'h8, 8'hD0);
    do_stb(1);
    do_wr(4'hD, 8'h00);
    chk(32'(chan_mask), 32'hF, "R13 masks set");
    chk(32'({ack_hi, req_hi, rot_prio}), 32'h0, "R13 command clear");
    do_rd(4'h8, "R13 status clear");
    rd16(4'h0, "R13 pointer low");

    // random phase
    void'($urandom(32'd20240611));
    do_wr(4'hE, 8'h00);
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom % 9);
      case (op)
        0, 1: do_wr(4'($urandom % 8), 8'($urandom));
        2:    do_wr(4'hB, 8'($urandom));
        3:    do_wr(4'hA, 8'($urandom % 8));
        4, 5: do_stb(int'($urandom % 4));
        6:    do_rd(4'($urandom % 8), "R2 random read");
        7:    do_rd(4'h8, "R11 random status");
        default: if ($urandom % 2 == 0) do_wr(4'hE, 8'h00); else do_wr(4'hC, 8'h00);
      endcase
      chk(32'(chan_mask), 32'(m_mask), "R9 random mask");
    end
    for (int c = 0; c < 4; c++) chk(32'(chan_mode[c*6 +: 6]), 32'(m_mode[c]), "R6 random mode");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule